// File: doc/BRIEF.md
# Shift and Rotate Unit with Carry and Overflow Flags

This block is a purely combinational execution unit for integer shift and rotate operations. A source value is treated as 1, 2, 4 or 8 bytes wide. The unit applies one of seven operations: logical left, logical right, arithmetic right, rotate right, rotate left, rotate right through carry and rotate left through carry. It writes the result into the low bytes of a destination value, and the upper bytes of that value pass through unchanged. It also produces updated carry (CF), extended carry (ECF) and overflow (OF) flags.

Each flag has its own enable bit. A flag is replaced only when its enable bit is set and the effective count is non-zero. Otherwise the incoming flag value passes through. Zero, sign and parity flags are produced by a neighbouring block and do not appear here. A typical caller presents the operands, the old destination and the old flags in one cycle, then registers `dest_o` and `flags_o` into its own state.

Top module: `shift_rotate_unit`

## Requirements
- R1: The effective count is the full 6-bit `amt_i` when `size_i` is 3 (8 bytes). For the other sizes it is `amt_i[4:0]`. The size encoding is 0, 1, 2, 3 for 1, 2, 4, 8 bytes.
- R2: With an effective count of zero, `flags_o` equals `flags_i`. The four rotate operations also return `dest_i` unchanged. The three shift operations still merge the source into the low bytes.
- R3: Flag bits are CF at bit 0, ECF at bit 1 and OF at bit 2. A bit whose `flag_en_i` bit is clear keeps its value from `flags_i`. An enabled bit takes the computed value, and CF and ECF both receive the same carry value.
- R4: For every operation that writes, `dest_o` bits above the selected size equal `dest_i`, and the low bytes hold the result.
- R5: Logical left (op 0) fills with zeros. The carry is source bit (width - count), or 0 when count > width. OF is the carry XOR the result MSB.
- R6: Logical right (op 1) fills with zeros. The carry is source bit (count - 1), or 0 when count > width. OF is the source MSB.
- R7: Arithmetic right (op 2) fills with the source sign bit. The carry is source bit (count - 1), or the sign bit when count > width. An enabled OF is written as 0.
- R8: Rotate right (op 3) rotates by the count modulo the width. CF is the result MSB. OF is the result MSB XOR the result's second-highest bit.
- R9: Rotate left (op 4) rotates by the count modulo the width. CF is the result LSB. OF is the result MSB XOR the result LSB.
- R10: Rotate right through carry (op 5) rotates the (width+1)-bit value {CF, source} by the count modulo (width+1). The new CF is the bit that lands on top, which is source bit (count - 1). OF is the old CF XOR the source MSB.
- R11: Rotate left through carry (op 6) does the same rotation to the left. The new CF is source bit (width - count). OF is the result MSB XOR the new CF.
- R12: Op code 7 is a no-operation: `dest_o` equals `dest_i` and `flags_o` equals `flags_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_i | input | 3 | Operation select (0..6 as in R5 to R11, 7 = no-op) |
| size_i | input | 2 | Operand size: 0=1, 1=2, 2=4, 3=8 bytes |
| src_i | input | 64 | Value to be shifted or rotated |
| amt_i | input | 6 | Low bits of the count operand |
| dest_i | input | 64 | Previous destination value |
| flag_en_i | input | 3 | Per-flag update enables {OF, ECF, CF} |
| flags_i | input | 3 | Previous flags {OF, ECF, CF} |
| dest_o | output | 64 | Merged destination result |
| flags_o | output | 3 | Updated flags {OF, ECF, CF} |

## Verification
The unit holds no state, so a wrong internal signal shows at the ports in the same cycle as the operands that trigger it. A fault in the count mask shows up as a wrong result or carry only at counts of 32 and above, and only at the sizes that mask to 5 bits. A wrong width lane shows up only in that lane's size and in its fill or carry bits. The bench therefore sweeps every count, size and operation against an independent one-bit-per-step model, with several source patterns and both carry-in values. Lapses in zero-count handling or the enable mask would corrupt `flags_o` or the upper destination bytes, so those are checked on dedicated vectors as well.

// File: rtl/shrot_pkg.sv
// Shared types for the shift/rotate unit: operation encoding and flag positions.
package shrot_pkg;

    // Operation codes; the numeric values are part of the port contract.
    typedef enum logic [2:0] {
        OP_SLL  = 3'd0,
        OP_SRL  = 3'd1,
        OP_SRA  = 3'd2,
        OP_ROR  = 3'd3,
        OP_ROL  = 3'd4,
        OP_RCR  = 3'd5,
        OP_RCL  = 3'd6,
        OP_NONE = 3'd7
    } shop_e;

    // Flag bit positions inside the 3-bit flag vectors.
    localparam int FL_CF  = 0;
    localparam int FL_ECF = 1;
    localparam int FL_OF  = 2;
    localparam int FLAG_W = 3;

endpackage

// File: rtl/shrot_count.sv
// Effective count: keeps all CNT_W bits for the widest size, drops the top bit
// for every narrower size. Assumes size code NUM_SIZES-1 is the widest lane.
module shrot_count #(
    parameter int NUM_SIZES = 4,
    parameter int SIZE_W    = 2,
    parameter int CNT_W     = 6
) (
    input  logic [SIZE_W-1:0] size_i,
    input  logic [CNT_W-1:0]  amt_i,
    output logic [CNT_W-1:0]  cnt_o,
    output logic              zero_o
);
    localparam logic [SIZE_W-1:0] SIZE_WIDEST = SIZE_W'(NUM_SIZES - 1);

    // Mask the count according to the operand size.
    always_comb begin
        if (size_i == SIZE_WIDEST) cnt_o = amt_i;
        else                       cnt_o = {1'b0, amt_i[CNT_W-2:0]};
        zero_o = (cnt_o == '0);
    end

    // Narrow sizes must never see the top count bit.
    always_comb begin
        if (size_i != SIZE_WIDEST) begin
            a_r1_narrow_count: assert (cnt_o[CNT_W-1] == 1'b0);
        end
    end

endmodule

// File: rtl/shrot_lane.sv
// One fixed-width shift/rotate lane. Computes the W-bit result and the raw
// carry and overflow bits for the selected operation. It assumes the count
// is already masked and that W is a power of two not wider than 2**CNT_W.
module shrot_lane
    import shrot_pkg::*;
#(
    parameter int W     = 8,
    parameter int CNT_W = 6
) (
    input  shop_e            op_i,
    input  logic [W-1:0]     src_i,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic             cf_i,
    output logic [W-1:0]     res_o,
    output logic             carry_o,
    output logic             ovf_o
);
    localparam int WL  = $clog2(W);
    localparam int WP1 = W + 1;

    logic [W:0]       sl_ext;   // {carry, result} of a left shift
    logic [W:0]       sr_ext;   // {result, carry} of a logical right shift
    logic [W:0]       sa_ext;   // {result, carry} of an arithmetic right shift
    logic [WL-1:0]    rot_amt;  // count modulo W
    logic [CNT_W-1:0] rc_amt;   // count modulo W+1
    logic [W-1:0]     ror_res;
    logic [W-1:0]     rol_res;
    logic [W:0]       rc_vec;
    logic [W:0]       rcr_v;
    logic [W:0]       rcl_v;

    // Shifts: one extra bit beside the data catches the last bit moved out.
    always_comb begin
        sl_ext = {1'b0, src_i} << cnt_i;
        sr_ext = {src_i, 1'b0} >> cnt_i;
        sa_ext = $signed({src_i, 1'b0}) >>> cnt_i;
    end

    // Rotates: a doubled operand turns rotation into a plain shift.
    always_comb begin
        rot_amt = cnt_i[WL-1:0];
        rc_amt  = CNT_W'(32'(cnt_i) % WP1);
        rc_vec  = {cf_i, src_i};
        ror_res = W'({src_i, src_i} >> rot_amt);
        rol_res = W'(({src_i, src_i} << rot_amt) >> W);
        rcr_v   = (W+1)'({rc_vec, rc_vec} >> rc_amt);
        rcl_v   = (W+1)'(({rc_vec, rc_vec} << rc_amt) >> (W+1));
    end

    // Select the result and apply the per-operation carry/overflow rule.
    always_comb begin
        case (op_i)
            OP_SLL: begin
                res_o   = sl_ext[W-1:0];
                carry_o = sl_ext[W];
                ovf_o   = sl_ext[W] ^ sl_ext[W-1];
            end
            OP_SRL: begin
                res_o   = sr_ext[W:1];
                carry_o = sr_ext[0];
                ovf_o   = src_i[W-1];
            end
            OP_SRA: begin
                res_o   = sa_ext[W:1];
                carry_o = sa_ext[0];
                ovf_o   = 1'b0;
            end
            OP_ROR: begin
                res_o   = ror_res;
                carry_o = ror_res[W-1];
                ovf_o   = ror_res[W-1] ^ ror_res[W-2];
            end
            OP_ROL: begin
                res_o   = rol_res;
                carry_o = rol_res[0];
                ovf_o   = rol_res[W-1] ^ rol_res[0];
            end
            OP_RCR: begin
                res_o   = rcr_v[W-1:0];
                carry_o = rcr_v[W];
                ovf_o   = cf_i ^ src_i[W-1];
            end
            OP_RCL: begin
                res_o   = rcl_v[W-1:0];
                carry_o = rcl_v[W];
                ovf_o   = rcl_v[W-1] ^ rcl_v[W];
            end
            default: begin
                res_o   = src_i;
                carry_o = cf_i;
                ovf_o   = 1'b0;
            end
        endcase
    end

    // Lane-level checks on fill and carry behaviour.
    always_comb begin
        if (op_i == OP_SRA && src_i[W-1]) begin
            a_r7_sign_fill: assert (res_o[W-1] == 1'b1);
        end
        if (op_i == OP_SRL && cnt_i != '0) begin
            a_r6_zero_fill: assert (res_o[W-1] == 1'b0);
        end
        if (op_i == OP_ROR && cnt_i != '0) begin
            a_r8_ror_carry: assert (carry_o == res_o[W-1]);
        end
    end

endmodule

// File: rtl/shrot_flags.sv
// Flag update: every enabled flag among CF, ECF and OF takes its computed
// value when the operation is active (valid op, non-zero count); all other
// flags pass through. Assumes carry/overflow come from the selected lane.
module shrot_flags
    import shrot_pkg::*;
(
    input  shop_e             op_i,
    input  logic              zero_i,
    input  logic [FLAG_W-1:0] en_i,
    input  logic [FLAG_W-1:0] flags_i,
    input  logic              carry_i,
    input  logic              ovf_i,
    output logic [FLAG_W-1:0] flags_o
);
    logic              active;
    logic [FLAG_W-1:0] computed;

    // Build the candidate flag vector and merge it under the enable mask.
    always_comb begin
        active             = (op_i != OP_NONE) && !zero_i;
        computed           = '0;
        computed[FL_CF]    = carry_i;
        computed[FL_ECF]   = carry_i;
        computed[FL_OF]    = ovf_i;
        for (int b = 0; b < FLAG_W; b++) begin
            flags_o[b] = (active && en_i[b]) ? computed[b] : flags_i[b];
        end
    end

endmodule

// File: rtl/shift_rotate_unit.sv
// Top of the shift/rotate unit. One lane per operand size is built by a
// generate loop; the lane picked by size_i supplies the result and raw flags,
// which are merged into the destination and flag vectors. Purely combinational.
module shift_rotate_unit
    import shrot_pkg::*;
#(
    parameter  int XLEN      = 64,
    localparam int NUM_SIZES = $clog2(XLEN / 8) + 1,
    localparam int SIZE_W    = $clog2(NUM_SIZES),
    localparam int CNT_W     = $clog2(XLEN)
) (
    input  logic [2:0]        op_i,
    input  logic [SIZE_W-1:0] size_i,
    input  logic [XLEN-1:0]   src_i,
    input  logic [CNT_W-1:0]  amt_i,
    input  logic [XLEN-1:0]   dest_i,
    input  logic [2:0]        flag_en_i,
    input  logic [2:0]        flags_i,
    output logic [XLEN-1:0]   dest_o,
    output logic [2:0]        flags_o
);
    shop_e                 op;
    logic [CNT_W-1:0]      cnt;
    logic                  cnt_zero;
    logic [XLEN-1:0]       lane_res  [NUM_SIZES];
    logic [XLEN-1:0]       lane_mask [NUM_SIZES];
    logic [NUM_SIZES-1:0]  lane_c;
    logic [NUM_SIZES-1:0]  lane_o;
    logic [XLEN-1:0]       sel_res;
    logic [XLEN-1:0]       sel_mask;
    logic                  keep_dest;

    assign op = shop_e'(op_i);

    shrot_count #(
        .NUM_SIZES (NUM_SIZES),
        .SIZE_W    (SIZE_W),
        .CNT_W     (CNT_W)
    ) count_i (
        .size_i (size_i),
        .amt_i  (amt_i),
        .cnt_o  (cnt),
        .zero_o (cnt_zero)
    );

    for (genvar s = 0; s < NUM_SIZES; s++) begin : g_lane
        localparam int W = 8 << s;
        logic [W-1:0] res_w;

        shrot_lane #(
            .W     (W),
            .CNT_W (CNT_W)
        ) lane_i (
            .op_i    (op),
            .src_i   (src_i[W-1:0]),
            .cnt_i   (cnt),
            .cf_i    (flags_i[FL_CF]),
            .res_o   (res_w),
            .carry_o (lane_c[s]),
            .ovf_o   (lane_o[s])
        );

        assign lane_res[s]  = XLEN'(res_w);
        assign lane_mask[s] = XLEN'({W{1'b1}});
    end

    // Pick the lane for the requested size.
    always_comb begin
        sel_res  = lane_res[size_i];
        sel_mask = lane_mask[size_i];
    end

    shrot_flags flags_u (
        .op_i    (op),
        .zero_i  (cnt_zero),
        .en_i    (flag_en_i),
        .flags_i (flags_i),
        .carry_i (lane_c[size_i]),
        .ovf_i   (lane_o[size_i]),
        .flags_o (flags_o)
    );

    // Merge the result into the low bytes; rotates by zero and no-ops keep dest.
    always_comb begin
        keep_dest = (op == OP_NONE) || (cnt_zero && op >= OP_ROR);
        if (keep_dest) dest_o = dest_i;
        else           dest_o = (dest_i & ~sel_mask) | (sel_res & sel_mask);
    end

    // Port-level checks on hold, merge and enable behaviour.
    always_comb begin
        if (cnt_zero) begin
            a_r2_zero_flags_held: assert (flags_o == flags_i);
        end
        if (cnt_zero && op >= OP_ROR) begin
            a_r2_zero_rotate_dest: assert (dest_o == dest_i);
        end
        a_r3_disabled_flags_held: assert (((flags_o ^ flags_i) & ~flag_en_i) == 3'b000);
        if (!cnt_zero && op != OP_NONE && flag_en_i[FL_CF] && flag_en_i[FL_ECF]) begin
            a_r3_carry_pair: assert (flags_o[FL_CF] == flags_o[FL_ECF]);
        end
        a_r4_upper_kept: assert ((dest_o & ~sel_mask) == (dest_i & ~sel_mask));
        if (op == OP_SRA && !cnt_zero && flag_en_i[FL_OF]) begin
            a_r7_no_overflow: assert (flags_o[FL_OF] == 1'b0);
        end
        if (op == OP_NONE) begin
            a_r12_noop_hold: assert (dest_o == dest_i && flags_o == flags_i);
        end
    end

endmodule

// File: tb/shift_rotate_unit_tb_top.sv
// Directed bench for shift_rotate_unit: hand-computed anchors per scenario plus
// a full sweep against a one-bit-per-step reference model.
module shift_rotate_unit_tb_top;

    logic        clk = 1'b0;
    logic [2:0]  op_i;
    logic [1:0]  size_i;
    logic [63:0] src_i;
    logic [5:0]  amt_i;
    logic [63:0] dest_i;
    logic [2:0]  flag_en_i;
    logic [2:0]  flags_i;
    logic [63:0] dest_o;
    logic [2:0]  flags_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    shift_rotate_unit dut_i (
        .op_i      (op_i),
        .size_i    (size_i),
        .src_i     (src_i),
        .amt_i     (amt_i),
        .dest_i    (dest_i),
        .flag_en_i (flag_en_i),
        .flags_i   (flags_i),
        .dest_o    (dest_o),
        .flags_o   (flags_o)
    );

    // Reference: step the operation one bit at a time per the requirements.
    function automatic void ref_model(
        input  logic [2:0]  op,  input logic [1:0] sz,
        input  logic [63:0] src, input logic [63:0] dst,
        input  logic [5:0]  amt, input logic [2:0] en, input logic [2:0] fl,
        output logic [63:0] d_exp, output logic [2:0] f_exp);
        int          w;
        int          n;
        logic [63:0] m;
        logic [63:0] top;
        logic [63:0] v;
        logic        c;
        logic        cn;
        logic        o;
        logic        src_msb;
        logic        v_msb;
        w   = 8 << sz;
        n   = (sz == 2'd3) ? int'(amt) : int'(amt[4:0]);
        m   = (w == 64) ? 64'hFFFF_FFFF_FFFF_FFFF : ((64'd1 << w) - 64'd1);
        top = 64'd1 << (w - 1);
        v   = src & m;
        c   = fl[0];
        src_msb = (v & top) != 0;
        for (int i = 0; i < n; i++) begin
            case (op)
                3'd0: begin c = (v & top) != 0; v = (v << 1) & m; end
                3'd1: begin c = v[0]; v = v >> 1; end
                3'd2: begin c = v[0]; v = (v >> 1) | (v & top); end
                3'd3: begin v = (v >> 1) | (v[0] ? top : 64'd0); end
                3'd4: begin v = ((v << 1) & m) | {63'd0, (v & top) != 0}; end
                3'd5: begin cn = v[0]; v = (v >> 1) | (c ? top : 64'd0); c = cn; end
                3'd6: begin cn = (v & top) != 0; v = ((v << 1) & m) | {63'd0, c}; c = cn; end
                default: ;
            endcase
        end
        v_msb = (v & top) != 0;
        case (op)
            3'd0: o = c ^ v_msb;
            3'd1: o = src_msb;
            3'd2: o = 1'b0;
            3'd3: begin c = v_msb; o = v_msb ^ (((v >> (w - 2)) & 64'd1) != 0); end
            3'd4: begin c = v[0]; o = v_msb ^ v[0]; end
            3'd5: o = fl[0] ^ src_msb;
            3'd6: o = v_msb ^ c;
            default: o = 1'b0;
        endcase
        if (op == 3'd7) begin
            d_exp = dst;
            f_exp = fl;
        end else if (n == 0) begin
            f_exp = fl;
            d_exp = (op >= 3'd3) ? dst : ((dst & ~m) | (src & m));
        end else begin
            d_exp    = (dst & ~m) | v;
            f_exp[0] = en[0] ? c : fl[0];
            f_exp[1] = en[1] ? c : fl[1];
            f_exp[2] = en[2] ? o : fl[2];
        end
    endfunction

    // Drive one vector after a rising edge, compare at the following falling edge.
    task automatic run_vec(input string tag, input logic [2:0] op, input logic [1:0] sz,
                           input logic [63:0] src, input logic [5:0] amt,
                           input logic [63:0] dst, input logic [2:0] en,
                           input logic [2:0] fl, input logic [63:0] exp_d,
                           input logic [2:0] exp_f);
        @(posedge clk);
        op_i = op; size_i = sz; src_i = src; amt_i = amt;
        dest_i = dst; flag_en_i = en; flags_i = fl;
        @(negedge clk);
        n_checks++;
        if (dest_o !== exp_d || flags_o !== exp_f) begin
            n_fail++;
            $display("FAIL %s op=%0d size=%0d amt=%0d: dest=%h flags=%b, expected dest=%h flags=%b",
                     tag, op, sz, amt, dest_o, flags_o, exp_d, exp_f);
        end
    endtask

    task automatic run_model(input string tag, input logic [2:0] op, input logic [1:0] sz,
                             input logic [63:0] src, input logic [5:0] amt,
                             input logic [63:0] dst, input logic [2:0] en,
                             input logic [2:0] fl);
        logic [63:0] ed;
        logic [2:0]  ef;
        ref_model(op, sz, src, dst, amt, en, fl, ed, ef);
        run_vec(tag, op, sz, src, amt, dst, en, fl, ed, ef);
    endtask

    // Quiet inputs: all zero gives zero outputs.
    task automatic t_idle();
        run_vec("R2 idle", 3'd0, 2'd0, 64'd0, 6'd0, 64'd0, 3'b000, 3'b000, 64'd0, 3'b000);
    endtask

    // R1: count masking by size.
    task automatic t_count_mask();
        run_vec("R1 byte amt 33->1", 3'd0, 2'd0, 64'h81, 6'd33, 64'd0, 3'b111, 3'b000,
                64'h02, 3'b111);
        run_vec("R1 qword amt 32", 3'd0, 2'd3, 64'd1, 6'd32, 64'd0, 3'b111, 3'b111,
                64'h1_0000_0000, 3'b000);
        run_vec("R1 dword amt 32->0", 3'd1, 2'd2, 64'hFFFF_FFFF_8000_0001, 6'd32,
                64'hAAAA_AAAA_0000_0000, 3'b111, 3'b101, 64'hAAAA_AAAA_8000_0001, 3'b101);
    endtask

    // R2: zero count holds flags, rotates hold the destination.
    task automatic t_zero_count();
        run_vec("R2 ror zero", 3'd3, 2'd0, 64'h5A, 6'd0, 64'h1234, 3'b111, 3'b010,
                64'h1234, 3'b010);
        run_vec("R2 rcl zero", 3'd6, 2'd1, 64'h5A5A, 6'd0, 64'h7777, 3'b111, 3'b101,
                64'h7777, 3'b101);
        run_vec("R2 sll zero", 3'd0, 2'd0, 64'hC3, 6'd0, 64'hFF00, 3'b111, 3'b011,
                64'hFFC3, 3'b011);
    endtask

    // R3: enable mask selects which flags change.
    task automatic t_enable_mask();
        run_vec("R3 only CF", 3'd0, 2'd0, 64'h81, 6'd1, 64'd0, 3'b001, 3'b000, 64'h02, 3'b001);
        run_vec("R3 only OF", 3'd0, 2'd0, 64'h81, 6'd1, 64'd0, 3'b100, 3'b000, 64'h02, 3'b100);
        run_vec("R3 none", 3'd0, 2'd0, 64'h81, 6'd1, 64'd0, 3'b000, 3'b010, 64'h02, 3'b010);
        run_vec("R3 clear ECF", 3'd1, 2'd0, 64'h02, 6'd1, 64'd0, 3'b010, 3'b111, 64'h01, 3'b101);
    endtask

    // R4: upper bytes of the destination are preserved.
    task automatic t_merge();
        run_vec("R4 word srl", 3'd1, 2'd1, 64'h1234_5678_9ABC_8000, 6'd4,
                64'hFFFF_FFFF_FFFF_FFFF, 3'b111, 3'b000, 64'hFFFF_FFFF_FFFF_0800, 3'b100);
    endtask

    // R5..R11: hand-computed anchor per operation.
    task automatic t_anchors();
        run_vec("R5 sll", 3'd0, 2'd0, 64'h81, 6'd1, 64'd0, 3'b111, 3'b000, 64'h02, 3'b111);
        run_vec("R6 srl", 3'd1, 2'd0, 64'h81, 6'd1, 64'd0, 3'b111, 3'b000, 64'h40, 3'b111);
        run_vec("R7 sra", 3'd2, 2'd0, 64'h80, 6'd3, 64'd0, 3'b111, 3'b111, 64'hF0, 3'b000);
        run_vec("R8 ror", 3'd3, 2'd2, 64'h1, 6'd1, 64'd0, 3'b111, 3'b000, 64'h8000_0000, 3'b111);
        run_vec("R9 rol", 3'd4, 2'd0, 64'h80, 6'd1, 64'd0, 3'b111, 3'b000, 64'h01, 3'b111);
        run_vec("R10 rcr", 3'd5, 2'd0, 64'h01, 6'd1, 64'd0, 3'b111, 3'b001, 64'h80, 3'b111);
        run_vec("R11 rcl", 3'd6, 2'd0, 64'h80, 6'd1, 64'd0, 3'b111, 3'b000, 64'h00, 3'b111);
    endtask

    // R12: op 7 leaves everything untouched.
    task automatic t_noop();
        run_vec("R12 noop", 3'd7, 2'd3, 64'hFFFF, 6'd5, 64'h0BAD_F00D, 3'b111, 3'b110,
                64'h0BAD_F00D, 3'b110);
    endtask

    // R5..R11 sweep: all ops, sizes, counts, three sources, both carry-ins.
    task automatic t_sweep();
        logic [63:0] pats [3];
        string       tags [7];
        pats[0] = 64'h8000_0000_0000_0001;
        pats[1] = 64'hA5C3_0F96_7E18_5AF1;
        pats[2] = 64'h7FFF_00FF_8001_FF80;
        tags[0] = "R5 sweep"; tags[1] = "R6 sweep"; tags[2] = "R7 sweep";
        tags[3] = "R8 sweep"; tags[4] = "R9 sweep"; tags[5] = "R10 sweep";
        tags[6] = "R11 sweep";
        for (int op = 0; op < 7; op++) begin
            for (int sz = 0; sz < 4; sz++) begin
                for (int a = 0; a < 64; a++) begin
                    for (int p = 0; p < 3; p++) begin
                        for (int cf = 0; cf < 2; cf++) begin
                            run_model(tags[op], 3'(op), 2'(sz), pats[p], 6'(a),
                                      64'hDEAD_BEEF_0123_4567,
                                      (a % 5 == 0) ? 3'(a ^ sz) : 3'b111,
                                      (cf != 0) ? 3'b101 : 3'b010);
                        end
                    end
                end
            end
        end
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog (all requirements): actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        op_i = 3'd0; size_i = 2'd0; src_i = '0; amt_i = '0;
        dest_i = '0; flag_en_i = '0; flags_i = '0;
        repeat (2) @(posedge clk);
        t_idle();
        t_count_mask();
        t_zero_count();
        t_enable_mask();
        t_merge();
        t_anchors();
        t_noop();
        t_sweep();
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule